// File: doc/BRIEF.md
# Vacuum Fluorescent Display Scan Controller

This block refreshes a multiplexed vacuum fluorescent display from its own 96-byte display memory, so the processor never has to service the scan. The processor writes segment patterns and a few configuration registers through a simple write port. A scan engine then visits the grids one time slot at a time. Each slot opens with a dark blanking interval, followed by a display interval. During the display interval exactly one digit line is driven and the segment lines carry that grid's stored pattern.

A 4-bit grid pointer counts down from a reload value to zero and then starts the next frame at the reload value again. The reload value sets how many digits are scanned. Segment lines come in six groups, and a group mask switches each group between display use and idle. A write that would raise the number of active display pins above 52 is refused. Two sticky interrupt flags mark the start of each blanking interval and the start of each display interval.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: Display memory address 16*r+p (r = 0..5, p = 0..15) holds the pattern for region r and grid pointer p. Regions 0..4 drive seg_o[8r+7:8r]. Region 5 drives only its bits 1:0, on seg_o[41:40].
- R2: During display the pointer decrements by one per slot, from the reload value down to 0, and the slot after 0 uses the reload value again. The only active digit line is dig_o bit equal to the pointer.
- R3: Each slot is (B+2) blanking cycles followed by DISP_CYC display cycles, where B is bits 3:1 of the control register at address 0x61. During blanking dig_o and seg_o are all zero.
- R4: A reload write (address 0x60, data bits 3:0) below 5 is stored as 5, so at least 6 digits are scanned.
- R5: The segment count is 8 for each set mask bit 0..4 plus 2 for mask bit 5. A write to the reload register is ignored, leaving the old value, if segment count + reload + 1 would exceed 52. A write to the group mask is ignored under the same rule.
- R6: The group mask register (address 0x62, bits 5:0, bit r for region r) forces the segment lines of every cleared group to zero.
- R7: irq_digit_o sets when a display interval starts. irq_blank_o sets when a blanking interval starts. Both stay set until a 1 is written to address 0x63, with bit 0 clearing the digit flag and bit 1 clearing the blank flag. A new event in the same cycle wins over the clear.
- R8: A memory write that arrives in the cycle in which the scan fetches a slot's patterns is committed one cycle later. The scan therefore shows the old byte for that slot.
- R9: With control bit 0 clear, all digit and segment lines are zero and the pointer holds the reload value. After the enable is set, the scan begins with a blanking interval at the reload value.
- R10: After reset the reload value is 5, the mask is 0x3F, the scan is disabled and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en_i | input | 1 | Register/memory write strobe |
| wr_addr_i | input | 7 | Write address: 0..95 memory, 0x60..0x63 registers |
| wr_data_i | input | 8 | Write data |
| seg_o | output | 42 | Segment lines |
| dig_o | output | 16 | Digit lines, at most one active |
| irq_digit_o | output | 1 | Sticky display-start flag |
| irq_blank_o | output | 1 | Sticky blanking-start flag |

## Verification
A register write takes effect at the clock edge that samples it, so the bench reads configuration and flag results on the next falling edge. After the enable edge the lines stay dark for exactly B+2 samples and then stay lit for DISP_CYC samples. The bench counts those samples at falling edges instead of waiting loosely. The fetch cycle is the first dark sample after a display interval. The collision test drives its write at that sample, so the write meets the fetch edge, and then checks the old byte in the following slot and the new byte one frame later.

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl #(
  parameter int DISP_CYC  = 8,
  parameter int PIN_LIMIT = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [6:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  output logic [41:0] seg_o,
  output logic [15:0] dig_o,
  output logic        irq_digit_o,
  output logic        irq_blank_o
);
  localparam int WORDS   = 96;
  localparam int CNT_MAX = (DISP_CYC > 10) ? DISP_CYC : 10;
  localparam int CNT_W   = $clog2(CNT_MAX);

  logic [7:0]       ram [WORDS];
  logic [3:0]       rl_q, ptr_q;
  logic [5:0]       mask_q;
  logic             en_q, disp_q;
  logic [2:0]       blank_q;
  logic [CNT_W-1:0] cnt_q;
  logic [41:0]      lat_q, mexp;
  logic             irqd_q, irqb_q;
  logic             pend_q;
  logic [6:0]       pend_a;
  logic [7:0]       pend_d;

  function automatic int seg_count(input logic [5:0] m);
    return 8 * $countones(m[4:0]) + 2 * int'(m[5]);
  endfunction

  wire       fetch     = en_q && !disp_q && cnt_q == '0;
  wire       disp_go   = en_q && disp_q && cnt_q == '0;
  wire       ram_wr    = wr_en_i && wr_addr_i < 7'd96;
  wire       blank_end = !disp_q && cnt_q == CNT_W'(blank_q) + CNT_W'(1);
  wire       disp_end  = disp_q && cnt_q == CNT_W'(DISP_CYC - 1);
  wire [3:0] rl_new    = (wr_data_i[3:0] < 4'd5) ? 4'd5 : wr_data_i[3:0];
  wire       rl_ok     = seg_count(mask_q) + int'(rl_new) + 1 <= PIN_LIMIT;
  wire       mask_ok   = seg_count(wr_data_i[5:0]) + int'(rl_q) + 1 <= PIN_LIMIT;
  wire       clr_wr    = wr_en_i && wr_addr_i == 7'h63;

  always_ff @(posedge clk) begin
    if (pend_q) ram[pend_a] <= pend_d;
    if (ram_wr && !fetch) ram[wr_addr_i] <= wr_data_i;
    if (fetch) begin
      for (int g = 0; g < 5; g++) lat_q[8*g +: 8] <= ram[7'(16*g) + 7'(ptr_q)];
      lat_q[41:40] <= ram[7'd80 + 7'(ptr_q)][1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else begin
      pend_q <= ram_wr && fetch;
      pend_a <= wr_addr_i;
      pend_d <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rl_q    <= 4'd5;
      mask_q  <= 6'h3F;
      en_q    <= 1'b0;
      blank_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == 7'h60 && rl_ok) rl_q <= rl_new;
      if (wr_addr_i == 7'h61) {blank_q, en_q} <= wr_data_i[3:0];
      if (wr_addr_i == 7'h62 && mask_ok) mask_q <= wr_data_i[5:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= 4'd5;
      disp_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_q) begin
      ptr_q  <= rl_q;
      disp_q <= 1'b0;
      cnt_q  <= '0;
    end else if (blank_end) begin
      disp_q <= 1'b1;
      cnt_q  <= '0;
    end else if (disp_end) begin
      disp_q <= 1'b0;
      cnt_q  <= '0;
      ptr_q  <= (ptr_q == 4'd0) ? rl_q : ptr_q - 4'd1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqd_q <= 1'b0;
      irqb_q <= 1'b0;
    end else begin
      irqd_q <= (irqd_q && !(clr_wr && wr_data_i[0])) || disp_go;
      irqb_q <= (irqb_q && !(clr_wr && wr_data_i[1])) || fetch;
    end
  end

  always_comb begin
    for (int g = 0; g < 5; g++) mexp[8*g +: 8] = {8{mask_q[g]}};
    mexp[41:40] = {2{mask_q[5]}};
  end

  assign seg_o       = (en_q && disp_q) ? (lat_q & mexp) : '0;
  assign dig_o       = (en_q && disp_q) ? (16'd1 << ptr_q) : '0;
  assign irq_digit_o = irqd_q;
  assign irq_blank_o = irqb_q;

  // R2
  dig_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dig_o));
  // R3
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n) (dig_o == '0) |-> (seg_o == '0));
  // R4
  reload_floor_chk: assert property (@(posedge clk) disable iff (!rst_n) rl_q >= 4'd5);
  // R5
  pin_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_count(mask_q) + int'(rl_q) + 1 <= PIN_LIMIT);
  // R7
  irq_digit_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(|dig_o) |=> irq_digit_o);
  // R8
  pend_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) pend_q |-> !fetch);
  // R9
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n) !en_q |=> (dig_o == '0));
endmodule

// File: tb/vfd_scan_ctrl_tb.sv
`timescale 1ns/1ps
module vfd_scan_ctrl_tb_top;
  localparam int DISP = 8;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [41:0] seg;
  logic [15:0] dig;
  logic irqd, irqb;
  int checks = 0, errors = 0;

  vfd_scan_ctrl #(.DISP_CYC(DISP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .seg_o(seg), .dig_o(dig), .irq_digit_o(irqd), .irq_blank_o(irqb));

  always #2.5 clk = ~clk;

  // {mask, reload written, first digit expected}
  localparam logic [15:0] VEC [8] = '{16'h3FF5, 16'h3F99, 16'h3FA5, 16'h1FC5,
                                      16'h1FBB, 16'h0FFF, 16'h0F25, 16'h03FF};

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  function automatic logic [41:0] exp_seg(input int p);
    logic [41:0] e;
    for (int g = 0; g < 5; g++) e[8*g +: 8] = pat(16*g + p);
    e[41:40] = pat(80 + p) & 8'h03;
    return e;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_lit(output int idx);
    int n = 0;
    while (dig == '0 && n < 500) begin @(negedge clk); n++; end
    idx = -1;
    for (int i = 0; i < 16; i++) if (dig[i]) idx = i;
  endtask

  task automatic wait_dark();
    int n = 0;
    while (dig != '0 && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic count_dark(output int n, output int bad);
    n = 0; bad = 0;
    while (dig == '0 && n < 500) begin
      if (seg != '0) bad++;
      n++; @(negedge clk);
    end
  endtask

  task automatic count_lit(output int n);
    n = 0;
    while (dig != '0 && n < 500) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx, n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 dig", 64'(dig), 0);
    chk("R10 seg", 64'(seg), 0);
    chk("R10 irq", 64'({irqd, irqb}), 0);
    for (int a = 0; a < 96; a++) wr(7'(a), pat(a));
    // R9 idle stays dark
    bad = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (dig != '0 || seg != '0) bad++; end
    chk("R9 idle dark", 64'(bad), 0);
    // R10 default reload 5, R9 start with blanking
    wr(7'h61, 8'h01);
    count_dark(n, bad);
    chk("R9 blank before first digit", 64'(n), 2);
    wait_lit(idx);
    chk("R10 default reload", 64'(idx), 5);
    chk("R1 segments digit 5", 64'(seg), 64'(exp_seg(5)));
    // R2 pointer sequence
    for (int k = 1; k <= 6; k++) begin
      wait_dark(); wait_lit(idx);
      chk("R2 pointer", 64'(idx), 64'((k == 6) ? 5 : 5 - k));
      if (k < 6) chk("R1 segments", 64'(seg), 64'(exp_seg(5 - k)));
    end
    // R3 slot timing, B field 0 and 7
    wait_dark(); count_dark(n, bad);
    chk("R3 blank len B0", 64'(n), 2);
    chk("R3 dark segments", 64'(bad), 0);
    count_lit(n);
    chk("R3 display len", 64'(n), DISP);
    wr(7'h61, 8'h0F);
    wait_dark(); wait_lit(idx); count_lit(n); count_dark(n, bad);
    chk("R3 blank len B7", 64'(n), 9);
    chk("R3 dark segments B7", 64'(bad), 0);
    // R7 sticky flags and clears
    wr(7'h61, 8'h00);
    chk("R7 digit flag set", 64'(irqd), 1);
    chk("R7 blank flag set", 64'(irqb), 1);
    wr(7'h63, 8'h01);
    chk("R7 clear digit only", 64'({irqd, irqb}), 64'(2'b01));
    wr(7'h63, 8'h02);
    chk("R7 clear blank", 64'({irqd, irqb}), 0);
    // R4 R5 vector table
    for (int v = 0; v < 8; v++) begin
      wr(7'h61, 8'h00);
      wr(7'h60, 8'h05);
      wr(7'h62, VEC[v][15:8]);
      wr(7'h60, {4'h0, VEC[v][7:4]});
      wr(7'h61, 8'h01);
      wait_lit(idx);
      chk("R5 R4 first digit", 64'(idx), 64'(VEC[v][3:0]));
    end
    // R5 mask write refused, R6 groups gated
    wr(7'h61, 8'h00);
    wr(7'h60, 8'h05);
    wr(7'h62, 8'h03);
    wr(7'h60, 8'h0F);
    wr(7'h62, 8'h3F);
    wr(7'h61, 8'h01);
    wait_lit(idx);
    chk("R5 reload kept", 64'(idx), 15);
    chk("R6 R5 masked groups zero", 64'(seg[41:16]), 0);
    chk("R6 enabled groups", 64'(seg[15:0]), 64'(exp_seg(15) & 42'hFFFF));
    // R8 collision
    wr(7'h61, 8'h00);
    wr(7'h62, 8'h3F);
    wr(7'h60, 8'h05);
    wr(7'h61, 8'h01);
    wait_lit(idx);
    wait_dark();
    wr_en = 1'b1; wr_addr = 7'd4; wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    wait_lit(idx);
    chk("R8 pointer", 64'(idx), 4);
    chk("R8 old byte shown", 64'(seg[7:0]), 64'(pat(4)));
    for (int k = 0; k < 6; k++) begin wait_dark(); wait_lit(idx); end
    chk("R8 pointer again", 64'(idx), 4);
    chk("R8 new byte later", 64'(seg[7:0]), 64'h3C);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule